// File: doc/BRIEF.md
# FSK Manchester Tag Demodulator

This block takes a stream of 8-bit amplitude samples from a low-frequency reader front end and recovers 44-bit tag identifiers. Each sample is sliced to one bit. The time between rising edges of the sliced signal tells whether the tag's carrier is running at the fast rate (one period in about 8 samples) or the slow rate (about 10 samples). The block counts how many periods of one rate follow each other, and turns each such run into half-bit symbols: fast is symbol 1 and slow is symbol 0.

A symbol-level framer searches the symbol stream for the start marker `111000`. After the marker it reads the symbols in pairs and decodes each pair as a Manchester bit. The bits shift into an identifier register. When the next marker arrives, a non-zero identifier is presented for one cycle.

Top module: `fsk_tag_demod`

## Requirements
- R1: A sample of 127 or more slices to 1, and a sample of 126 or less slices to 0.
- R2: Period timing starts at the first 0-to-1 change of the sliced signal seen after reset. Samples before that change only set the starting level.
- R3: When the spacing between two rising edges is less than 9 samples, the period is fast (symbol level 1). When the spacing is 9 samples or more, the period is slow (symbol level 0).
- R4: A run of n equal-rate periods is converted when the rate changes. A fast run gives (n+1)/6 symbols and a slow run gives (n+1)/5 symbols, both with integer division. For example, runs of 5, 6, 7, 11 or 13 fast periods give 1, 1, 1, 2 and 2 symbols.
- R5: A run that converts to 0 symbols, or to more than 4 symbols, adds nothing to the symbol stream.
- R6: While hunting, the last six symbols equal to 1,1,1,0,0,0 (oldest first) form a marker. A marker that finds an empty identifier register produces no output.
- R7: In a frame, the pair (0,1) decodes to bit 1 and the pair (1,0) decodes to bit 0. Each new bit enters at bit 0 of the 44-bit register, so the first bit received of a complete frame ends up in bit 43.
- R8: A marker that finds a non-zero register raises `id_valid` for exactly one cycle with `id_value` equal to the register, then clears the register. `id_value` holds its value between pulses and is zero after reset.
- R9: A pair (0,0) or (1,1) in a frame ends the frame and returns to hunting. The bits already collected are kept and are reported at the next marker.
- R10: Cycles with `smp_valid` low have no effect, whatever `smp_data` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Marks `smp_data` as a new sample |
| smp_data | input | 8 | Amplitude sample |
| id_valid | output | 1 | One-cycle pulse when an identifier is complete |
| id_value | output | 44 | Last completed identifier |

## Verification
The hardest paths to reach from the sample port are the dropped runs and the frame abort. Reaching them means shaping carrier run lengths precisely. A short slow burst inside a fast run must round to zero symbols, a long fast stretch must round to five, and an illegal pair must land exactly on a pair boundary.

The bench builds every stream as a list of symbols. It merges equal symbols into runs and converts each run into a number of carrier periods. It can also insert raw runs of a chosen period count between symbols. This lets it place these cases, and jittered period lengths and counts, at exact points inside otherwise valid frames.

// File: rtl/fsk_tag_demod.sv
module fsk_tag_demod #(
  parameter int SAMPLE_W = 8,
  parameter int THRESH   = 127,
  parameter int SPLIT    = 9,
  parameter int FAST_DIV = 6,
  parameter int SLOW_DIV = 5,
  parameter int MAX_SYM  = 4,
  parameter int CNT_W    = 8,
  parameter int RUN_W    = 8,
  parameter int ID_W     = 44
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  output logic                id_valid,
  output logic [ID_W-1:0]     id_value
);
  localparam int NSW = $clog2(MAX_SYM + 1);
  localparam logic [5:0] MARK = 6'b111000;

  logic             lvl_prev, synced;
  logic [CNT_W-1:0] gap;
  logic             lvl_now, rise, period_done, fast;

  assign lvl_now     = smp_data >= SAMPLE_W'(THRESH);
  assign rise        = smp_valid && lvl_now && !lvl_prev;
  assign period_done = rise && synced;
  assign fast        = gap < CNT_W'(SPLIT);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_prev <= 1'b1;
      synced   <= 1'b0;
      gap      <= '0;
    end else if (smp_valid) begin
      lvl_prev <= lvl_now;
      if (rise) begin
        synced <= 1'b1;
        gap    <= CNT_W'(1);
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end

  logic             run_act, run_lvl, run_end;
  logic [RUN_W-1:0] run_len;
  logic [RUN_W:0]   run_plus, sym_cnt;
  logic [NSW-1:0]   nsym;

  assign run_plus = {1'b0, run_len} + 1'b1;
  assign sym_cnt  = run_lvl ? run_plus / (RUN_W+1)'(FAST_DIV)
                            : run_plus / (RUN_W+1)'(SLOW_DIV);
  assign run_end  = period_done && run_act && (fast != run_lvl);
  assign nsym     = (run_end && sym_cnt != '0 && sym_cnt <= (RUN_W+1)'(MAX_SYM))
                    ? NSW'(sym_cnt) : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run_act <= 1'b0;
      run_lvl <= 1'b0;
      run_len <= '0;
    end else if (period_done) begin
      if (!run_act || fast != run_lvl) begin
        run_act <= 1'b1;
        run_lvl <= fast;
        run_len <= RUN_W'(1);
      end else if (run_len != '1) begin
        run_len <= run_len + 1'b1;
      end
    end

  logic            in_frame, half, first;
  logic [5:0]      hist;
  logic [ID_W-1:0] shreg;
  logic            nx_frame, nx_half, nx_first, fire;
  logic [5:0]      nx_hist;
  logic [ID_W-1:0] nx_shreg, fire_val;

  always_comb begin
    nx_frame = in_frame;
    nx_half  = half;
    nx_first = first;
    nx_hist  = hist;
    nx_shreg = shreg;
    fire     = 1'b0;
    fire_val = '0;
    for (int k = 0; k < MAX_SYM; k++) begin
      if (k < int'(nsym)) begin
        nx_hist = {nx_hist[4:0], run_lvl};
        if (!nx_frame) begin
          if (nx_hist == MARK) begin
            if (nx_shreg != '0) begin
              fire     = 1'b1;
              fire_val = nx_shreg;
            end
            nx_shreg = '0;
            nx_frame = 1'b1;
            nx_half  = 1'b0;
          end
        end else if (!nx_half) begin
          nx_first = run_lvl;
          nx_half  = 1'b1;
        end else begin
          nx_half = 1'b0;
          if (nx_first != run_lvl) nx_shreg = {nx_shreg[ID_W-2:0], run_lvl};
          else                     nx_frame = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_frame <= 1'b0;
      half     <= 1'b0;
      first    <= 1'b0;
      hist     <= '0;
      shreg    <= '0;
      id_valid <= 1'b0;
      id_value <= '0;
    end else begin
      in_frame <= nx_frame;
      half     <= nx_half;
      first    <= nx_first;
      hist     <= nx_hist;
      shreg    <= nx_shreg;
      id_valid <= fire;
      if (fire) id_value <= fire_val;
    end
endmodule

// File: rtl/fsk_tag_demod_chk.sv
module fsk_tag_demod_chk #(
  parameter int ID_W = 44
) (
  input logic            clk,
  input logic            rst_n,
  input logic            smp_valid,
  input logic            id_valid,
  input logic [ID_W-1:0] id_value
);
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |=> !id_valid);

  p_value_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> $stable(id_value));

  p_nonzero_id_r8: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid |-> id_value != '0);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> !id_valid);
endmodule

bind fsk_tag_demod fsk_tag_demod_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
  .id_valid(id_valid), .id_value(id_value)
);

// File: tb/fsk_tag_demod_tb.sv
module fsk_tag_demod_tb;
  logic        clk = 1'b0, rst_n = 1'b0, smp_valid = 1'b0;
  logic [7:0]  smp_data = '0;
  logic        id_valid;
  logic [43:0] id_value;

  always #4 clk = ~clk;

  fsk_tag_demod u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .id_valid(id_valid), .id_value(id_value)
  );

  int checks = 0, errors = 0, got = 0, scount = 0;
  bit jit = 1'b0, pend = 1'b0;
  int unsigned sq[$];
  logic [43:0] exp_q[$];
  string       tag_q[$];

  localparam logic [43:0] ID_A = 44'h1D2_3456_789A;
  localparam logic [43:0] ID_B = 44'hB3F_0C96_5A21;
  localparam logic [43:0] ID_C = 44'h07E_A1B2_C3D4;
  localparam logic [43:0] ID_D = 44'h8C4_5E2F_1B37;
  localparam logic [43:0] ID_E = 44'h3A9_6D5C_0E7F;
  localparam logic [43:0] ID_P = 44'h000_0000_00A6;

  // every seventh sample is followed by an idle cycle carrying inverted data (R10)
  task automatic put_sample(input logic [7:0] d);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_data  = d;
    scount++;
    if (scount % 7 == 0) begin
      @(negedge clk);
      smp_valid = 1'b0;
      smp_data  = ~d;
    end
  endtask

  task automatic send_run(input bit lvl, input int mode, input int cnt);
    int plen;
    int h;
    logic [7:0] hi, lo;
    plen = (mode == 2) ? (lvl ? 7 : 9) : (lvl ? 8 : 10);
    hi   = (mode == 1) ? 8'd127 : 8'd200;
    lo   = (mode == 1) ? 8'd126 : 8'd40;
    h    = (plen <= 8) ? 2 : 3;
    for (int p = 0; p < cnt; p++)
      for (int i = 0; i < plen; i++) put_sample(i < h ? hi : lo);
  endtask

  task automatic add_sym(input bit l, input int mode);
    sq.push_back(32'(l) | (32'(mode) << 1));
  endtask

  task automatic add_raw(input bit l, input int cnt);
    sq.push_back(32'(l) | (32'(cnt) << 8));
  endtask

  task automatic add_marker(input int mode);
    add_sym(1, mode); add_sym(1, mode); add_sym(1, mode);
    add_sym(0, mode); add_sym(0, mode); add_sym(0, mode);
  endtask

  task automatic add_bits(input logic [43:0] v, input int n, input int mode);
    for (int i = n - 1; i >= 0; i--) begin
      add_sym(!v[i], mode);
      add_sym(v[i], mode);
    end
  endtask

  task automatic expect_id(input logic [43:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic emit();
    int i, k, cnt, mode, raw;
    bit l;
    i = 0;
    while (i < sq.size()) begin
      l    = sq[i][0];
      mode = int'((sq[i] >> 1) & 3);
      raw  = int'(sq[i] >> 8);
      if (raw != 0) begin
        send_run(l, 0, raw);
        i++;
      end else begin
        k = 0;
        while (i < sq.size() && sq[i][0] == l && int'((sq[i] >> 1) & 3) == mode
               && (sq[i] >> 8) == 0) begin
          k++;
          i++;
        end
        cnt = (l ? 6 : 5) * k;
        if (mode == 2) begin
          cnt = cnt + (jit ? 1 : -1);
          jit = ~jit;
        end
        send_run(l, mode, cnt);
      end
    end
  endtask

  always @(negedge clk) begin
    logic [43:0] ev;
    string tg;
    if (rst_n) begin
      if (pend) begin
        checks++;
        if (id_valid) begin
          errors++;
          $display("FAIL R8 pulse wider than one cycle: id_valid=%0b expected 0", id_valid);
        end
        pend = 1'b0;
      end else if (id_valid) begin
        got++;
        pend = 1'b1;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R6 unexpected identifier: actual %h expected none", id_value);
        end else begin
          ev = exp_q.pop_front();
          tg = tag_q.pop_front();
          if (id_value !== ev) begin
            errors++;
            $display("FAIL %s identifier: actual %h expected %h", tg, id_value, ev);
          end
        end
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    checks++;
    if (id_valid !== 1'b0 || id_value !== 44'd0) begin
      errors++;
      $display("FAIL R8 reset state: actual %0b/%h expected 0/0", id_valid, id_value);
    end
    rst_n = 1'b1;

    // R2: steady high then low before the first rising edge
    for (int i = 0; i < 20; i++) put_sample(8'd200);
    for (int i = 0; i < 10; i++) put_sample(8'd40);

    add_raw(0, 40);                       // R5: 8 symbols, dropped
    add_marker(0);                        // R6: empty register, silent
    add_bits(ID_A, 44, 0); add_marker(0); expect_id(ID_A, "R2/R6/R7");
    add_bits(ID_B, 44, 1); add_marker(0); expect_id(ID_B, "R1");
    add_bits(ID_C, 44, 2); add_marker(2); expect_id(ID_C, "R3/R4");
    // R5: 30 fast periods -> 5 symbols dropped; 2 slow periods -> 0 symbols dropped
    add_raw(1, 30);
    add_sym(0, 0); add_sym(1, 0); add_raw(0, 2); add_sym(1, 0); add_sym(0, 0);
    add_bits(ID_D, 42, 0); add_marker(0); expect_id(ID_D, "R5");
    // R9: 8 bits, then a (0,0) pair, then junk pairs while hunting
    add_bits(ID_P, 8, 0); add_sym(0, 0); add_sym(0, 0);
    add_bits(44'h3, 2, 0); add_marker(0); expect_id(ID_P, "R9");
    add_bits(ID_E, 44, 0); add_marker(0); expect_id(ID_E, "R7/R10");
    add_sym(1, 0); add_sym(0, 0); add_raw(1, 12);
    emit();

    for (int i = 0; i < 20; i++) put_sample(8'd40);
    @(negedge clk);
    smp_valid = 1'b0;
    repeat (50) @(negedge clk);

    checks++;
    if (got != 6 || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R6 identifier count: actual %0d expected 6", got);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule